// File: doc/BRIEF.md
# Preamble Detector with Lock-Mode Handoff

This block recognises the preamble at the head of a read. It watches single-cycle read-data pulses that have already been synchronised to a fast system clock. For each pulse it measures the number of clocks since the previous pulse. It compares that spacing against one of four preamble spacings, chosen by a two-bit select. Once enough consecutive pulses arrive at the expected spacing, it raises a preamble-detected flag. That flag stays up until the read gate drops.

The block also derives the loop mode from an active-low frequency-lock control input, which may change at any time. While the read gate is high and the synchronised control is low, the loop is in frequency acquisition and the data window gating is off. Otherwise the loop is in phase lock and the window is on. When the loopback enable is set, a detected preamble forces the control high internally. Detection therefore ends frequency acquisition on its own. The bit-cell length in system clocks is a parameter (`CELL_CLKS`, default 8).

Top module: `preamble_lock_ctrl`

## Requirements
- R1: `pat_sel` encodes the preamble spacing as k cells: 0→1, 1→2, 2→3, 3→4. An interval between two counted pulses qualifies when it lies within k·CELL_CLKS ± CELL_CLKS/4 clocks, both bounds included.
- R2: The first pulse after arming is only a reference. `pre_det` rises at the clock edge of the pulse that completes the threshold run of qualifying intervals: 32 intervals for k = 1, 2 or 3, and 16 intervals for k = 4.
- R3: Pulses have no effect while `zps_done` is low. In particular, they neither count nor set a reference.
- R4: A non-qualifying interval resets the run to zero. That pulse then becomes the new reference.
- R5: Once `pre_det` is high, it stays high while `rd_gate` stays high. This holds even when later intervals do not qualify.
- R6: With `rd_gate` low at a clock edge, the run, the reference and `pre_det` are cleared by that edge.
- R7: The run counter saturates at its threshold. A long preamble never wraps it, so `pre_det` is not disturbed.
- R8: `freq_acq` equals `rd_gate` AND NOT ctl, where ctl is `lock_ctl_n` delayed through a two-flop synchroniser. A change on `lock_ctl_n` reaches `freq_acq` after the second rising edge.
- R9: `window_en` is always the inverse of `freq_acq`.
- R10: With `loop_en` high, ctl is also forced high while `pre_det` is high. As a result, `freq_acq` falls in the same cycle that `pre_det` rises.
- R11: Right after reset, `pre_det` and `freq_acq` are low and `window_en` is high. The synchroniser resets to the high (phase-lock) state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_gate | input | 1 | Read gate, already synchronous to `clk` |
| zps_done | input | 1 | Zero-phase-start sequence finished |
| data_pulse | input | 1 | One-cycle strobe per read-data pulse |
| pat_sel | input | 2 | Preamble spacing select (k = pat_sel + 1 cells) |
| lock_ctl_n | input | 1 | Active-low frequency-lock control, asynchronous |
| loop_en | input | 1 | Route detection into the lock-control path |
| pre_det | output | 1 | Preamble detected, sticky while read gate is high |
| freq_acq | output | 1 | Loop is in frequency-acquisition mode |
| window_en | output | 1 | Data window gating enabled (phase-lock mode) |

## Verification
The hardest situation to reach from the ports is a run that is broken late: a spacing just outside the tolerance band arrives after many good intervals, and the run must restart from that pulse rather than carry on. The stimulus drives pulse trains at both edges of the tolerance band, including intervals one clock outside it. A behavioural model, built from intervals and integer counts, follows every clock. The same approach covers the loopback handoff: a full preamble is driven with the external control held low, and `freq_acq` is expected to fall in the very cycle that detection rises.

// File: rtl/plk_pkg.sv
// Package: shared helpers for the preamble detector.
// Assumes the select encodes the spacing as (select + 1) bit cells.
package plk_pkg;

    typedef enum logic [1:0] {
        SPACE_1C = 2'd0,
        SPACE_2C = 2'd1,
        SPACE_3C = 2'd2,
        SPACE_4C = 2'd3
    } space_e;

    // Number of bit cells between pulses for a given select code.
    function automatic int unsigned cells_of(input logic [1:0] code);
        return int'(code) + 1;
    endfunction

endpackage

// File: rtl/plk_sync.sv
// Module: multi-flop synchroniser for a single asynchronous level.
// Assumes STAGES >= 2; all flops reset to RST_VAL.
module plk_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/plk_interval.sv
// Module: measures clocks between successive pulses and checks the
// interval against the selected spacing +/- a quarter cell.
// Assumes CELL_CLKS >= 4 and pulses are one-cycle strobes.
module plk_interval #(
    parameter int unsigned CELL_CLKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       enable,
    input  logic       pulse,
    input  logic [1:0] sel,
    output logic       ev_valid,
    output logic       ev_match
);
    import plk_pkg::*;

    localparam int unsigned SPAN_MAX = 5 * CELL_CLKS;
    localparam int unsigned TOL      = CELL_CLKS / 4;
    localparam int unsigned GW       = $clog2(SPAN_MAX + 2);

    logic [GW-1:0] gap_q;
    logic          ref_q;
    logic [GW-1:0] ivl;
    logic [GW-1:0] win_lo [4];
    logic [GW-1:0] win_hi [4];

    // Acceptance bounds, one pair per spacing code.
    for (genvar gi = 0; gi < 4; gi++) begin : g_win
        localparam int unsigned NOM = cells_of(2'(gi)) * CELL_CLKS;
        assign win_lo[gi] = GW'(NOM - TOL);
        assign win_hi[gi] = GW'(NOM + TOL);
    end

    // Track the reference pulse and count clocks since it, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ref_q <= 1'b0;
            gap_q <= '0;
        end else if (enable) begin
            if (pulse) begin
                ref_q <= 1'b1;
                gap_q <= '0;
            end else if (ref_q && gap_q != GW'(SPAN_MAX)) begin
                gap_q <= gap_q + GW'(1);
            end
        end
    end

    // Interval of the current pulse, then window comparison.
    always_comb begin
        ivl      = gap_q + GW'(1);
        ev_valid = enable && pulse && ref_q && !clear;
        ev_match = ev_valid && (ivl >= win_lo[sel]) && (ivl <= win_hi[sel]);
    end

    // R1: the gap counter never runs beyond its saturation point.
    a_r1_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= GW'(SPAN_MAX));

    // R3: with measurement disabled, the reference state holds.
    a_r3_hold_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !clear) |=> (ref_q == $past(ref_q)));
endmodule

// File: rtl/plk_runcount.sv
// Module: counts consecutive qualifying intervals and raises a sticky
// detection flag at the spacing-dependent threshold.
// Assumes RUN_LONG <= RUN_SHORT.
module plk_runcount #(
    parameter int unsigned RUN_SHORT = 32,
    parameter int unsigned RUN_LONG  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       ev_valid,
    input  logic       ev_match,
    input  logic [1:0] sel,
    output logic       det
);
    localparam int unsigned CW = $clog2(RUN_SHORT + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] need;
    logic [CW-1:0] cnt_inc;
    logic          det_q;

    // Threshold for the selected spacing and the saturating increment.
    always_comb begin
        need    = (sel == plk_pkg::SPACE_4C) ? CW'(RUN_LONG) : CW'(RUN_SHORT);
        cnt_inc = (cnt_q >= need) ? need : cnt_q + CW'(1);
    end

    // Update run length and latch detection.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
            det_q <= 1'b0;
        end else if (ev_valid) begin
            if (ev_match) begin
                cnt_q <= cnt_inc;
                if (cnt_inc == need) det_q <= 1'b1;
            end else begin
                cnt_q <= '0;
            end
        end
    end

    assign det = det_q;

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(RUN_SHORT));

    a_r5_det_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (det_q && !clear) |=> det_q);

    a_r6_gate_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!det_q && cnt_q == '0));

    a_r4_miss_resets: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_match && !clear) |=> (cnt_q == '0));
endmodule

// File: rtl/preamble_lock_ctrl.sv
// Module: top of the preamble detector with lock-mode handoff.
// Assumes rd_gate, zps_done and data_pulse are synchronous to clk;
// lock_ctl_n is asynchronous and is synchronised here.
module preamble_lock_ctrl #(
    parameter int unsigned CELL_CLKS   = 8,
    parameter int unsigned RUN_SHORT   = 32,
    parameter int unsigned RUN_LONG    = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_gate,
    input  logic       zps_done,
    input  logic       data_pulse,
    input  logic [1:0] pat_sel,
    input  logic       lock_ctl_n,
    input  logic       loop_en,
    output logic       pre_det,
    output logic       freq_acq,
    output logic       window_en
);
    logic clear;
    logic armed;
    logic ev_valid;
    logic ev_match;
    logic ctl_sync;
    logic ctl_eff;

    // Arming and clearing conditions for the measurement path.
    always_comb begin
        clear = !rd_gate;
        armed = rd_gate && zps_done;
    end

    plk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (lock_ctl_n),
        .q_sync  (ctl_sync)
    );

    plk_interval #(.CELL_CLKS(CELL_CLKS)) u_ivl (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .enable   (armed),
        .pulse    (data_pulse),
        .sel      (pat_sel),
        .ev_valid (ev_valid),
        .ev_match (ev_match)
    );

    plk_runcount #(.RUN_SHORT(RUN_SHORT), .RUN_LONG(RUN_LONG)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .ev_valid (ev_valid),
        .ev_match (ev_match),
        .sel      (pat_sel),
        .det      (pre_det)
    );

    // Loop mode: effective control merges loopback detection.
    always_comb begin
        ctl_eff   = ctl_sync || (loop_en && pre_det);
        freq_acq  = rd_gate && !ctl_eff;
        window_en = !freq_acq;
    end

    a_r8_acq_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
        freq_acq |-> rd_gate);

    a_r10_loop_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_en && pre_det) |-> !freq_acq);

    a_r3_no_rise_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_gate && !zps_done && !pre_det) |=> !pre_det);
endmodule

// File: tb/sim_preamble_lock_ctrl.sv
module sim_preamble_lock_ctrl;
    localparam int CELL = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_gate = 1'b0;
    logic       zps_done = 1'b0;
    logic       data_pulse = 1'b0;
    logic [1:0] pat_sel = 2'd0;
    logic       lock_ctl_n = 1'b0;
    logic       loop_en = 1'b0;
    logic       pre_det;
    logic       freq_acq;
    logic       window_en;

    int checks = 0;
    int errors = 0;

    // reference model state
    int  m_s1 = 1, m_s2 = 1, m_gap = 0, m_cnt = 0;
    bit  m_ref = 0, m_det = 0;

    always #5 clk = ~clk;

    preamble_lock_ctrl #(.CELL_CLKS(CELL)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_gate(rd_gate), .zps_done(zps_done),
        .data_pulse(data_pulse), .pat_sel(pat_sel), .lock_ctl_n(lock_ctl_n),
        .loop_en(loop_en), .pre_det(pre_det), .freq_acq(freq_acq),
        .window_en(window_en)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model updated every edge, compared shortly after
    always @(posedge clk) begin
        int  k, thr, iv;
        bit  fa;
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_gap = 0; m_cnt = 0; m_ref = 0; m_det = 0;
        end else begin
            m_s2 = m_s1;
            m_s1 = lock_ctl_n;
            if (!rd_gate) begin
                m_gap = 0; m_cnt = 0; m_ref = 0; m_det = 0;
            end else if (zps_done) begin
                if (data_pulse) begin
                    if (m_ref) begin
                        k   = pat_sel + 1;
                        thr = (k == 4) ? 16 : 32;
                        iv  = m_gap + 1;
                        if (iv >= k*CELL - CELL/4 && iv <= k*CELL + CELL/4) begin
                            m_cnt = (m_cnt + 1 > thr) ? thr : m_cnt + 1;
                            if (m_cnt == thr) m_det = 1;
                        end else begin
                            m_cnt = 0;
                        end
                    end
                    m_ref = 1;
                    m_gap = 0;
                end else if (m_ref && m_gap < 5*CELL) begin
                    m_gap = m_gap + 1;
                end
            end
        end
        #2;
        fa = rd_gate && !(m_s2 != 0 || (loop_en && m_det));
        check(pre_det, m_det, "R2 model pre_det");
        check(freq_acq, fa, "R8 model freq_acq");
        check(window_en, !fa, "R9 model window_en");
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // pulse placed d clocks after the previous one from this task
    task automatic emit(input int d);
        repeat (d - 2) @(negedge clk) data_pulse = 1'b0;
        @(negedge clk) data_pulse = 1'b1;
        @(negedge clk) data_pulse = 1'b0;
    endtask

    task automatic regate();
        @(negedge clk) rd_gate = 1'b0;
        @(negedge clk) rd_gate = 1'b1;
    endtask

    initial begin
        #2000000;
        errors++; checks++;
        $display("FAIL watchdog all requirements actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(4);
        check(pre_det, 1'b0, "R11 reset pre_det");
        check(freq_acq, 1'b0, "R11 reset freq_acq");
        check(window_en, 1'b1, "R11 reset window_en");
        rst_n = 1'b1;
        rd_gate = 1'b1;
        idle(3);
        check(freq_acq, 1'b1, "R8 control low gives acquisition");
        for (int i = 0; i < 40; i++) emit(CELL);
        check(pre_det, 1'b0, "R3 pulses ignored before zps_done");

        zps_done = 1'b1;
        for (int i = 0; i < 32; i++) emit(CELL);
        check(pre_det, 1'b0, "R2 31 intervals not enough");
        emit(CELL);
        check(pre_det, 1'b1, "R2 R1 detect after 32 intervals");
        for (int i = 0; i < 5; i++) emit(13);
        check(pre_det, 1'b1, "R5 sticky through bad intervals");
        for (int i = 0; i < 50; i++) emit(CELL);
        check(pre_det, 1'b1, "R7 long preamble no wrap");

        @(negedge clk) rd_gate = 1'b0;
        @(negedge clk);
        check(pre_det, 1'b0, "R6 gate low clears");
        check(window_en, 1'b1, "R9 window on without gate");
        rd_gate = 1'b1;

        pat_sel = 2'd3;
        emit(32);
        for (int i = 0; i < 15; i++) emit((i % 2) ? 34 : 30);
        check(pre_det, 1'b0, "R2 4-cell 15 intervals");
        emit(34);
        check(pre_det, 1'b1, "R1 R2 4-cell detect at 16 edge intervals");

        regate();
        pat_sel = 2'd1;
        emit(16);
        for (int i = 0; i < 20; i++) emit((i % 2) ? 18 : 14);
        emit(19);
        for (int i = 0; i < 31; i++) emit(16);
        check(pre_det, 1'b0, "R4 run restarted by outside interval");
        emit(16);
        check(pre_det, 1'b1, "R4 detect after fresh run");

        regate();
        pat_sel = 2'd2;
        loop_en = 1'b1;
        idle(2);
        check(freq_acq, 1'b1, "R10 acquisition before detect");
        emit(24);
        for (int i = 0; i < 32; i++) emit(24);
        check(pre_det, 1'b1, "R10 detect with loopback");
        check(freq_acq, 1'b0, "R10 loopback ends acquisition");
        check(window_en, 1'b1, "R9 window on after loopback");

        loop_en = 1'b0;
        idle(3);
        check(freq_acq, 1'b1, "R8 acquisition back without loopback");
        lock_ctl_n = 1'b1;
        @(negedge clk);
        check(freq_acq, 1'b1, "R8 one edge not yet through sync");
        @(negedge clk);
        check(freq_acq, 1'b0, "R8 two edges through sync");
        check(window_en, 1'b1, "R9 window follows");
        idle(2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule